// File: doc/BRIEF.md
# Serial Image Line Packet Parser

This block sits behind a byte-wide serial receiver and turns its byte stream into image-line writes. Each framed packet opens with a sync byte of 0x55. A control byte follows that selects horizontal and vertical mirroring. Next comes a two-byte row number, and the packet ends with one full line of three-byte colour pixels (512 pixels by default). The parser packs each pixel into a 32-bit word and emits it with a one-clock write strobe. After the final pixel of a line it raises a one-clock line-end pulse. With that pulse it presents the row number and updates the two mirroring flags for the downstream line buffer and memory writer.

The parser accepts one byte on every clock where the valid strobe is high and never stalls the sender. It does not check whether a packet is well formed. A truncated packet takes the bytes that follow it as payload until its fixed length is reached. After that the parser again discards everything up to the next 0x55, so the stream recovers without any outside help. Row numbers are forwarded as received, including values past the last row of the image.

Top module: `img_line_parser`

## Requirements
- R1: A synchronous reset clears pix_wr, line_end, pix_data, line_info, flip_h and flip_v to zero and returns the parser to hunting for sync.
- R2: While hunting for sync, every accepted byte other than 0x55 is discarded with no effect on any output, and the next accepted 0x55 starts a packet.
- R3: In the control byte (the first byte after sync), bit 4 set requests a horizontal flip and bit 0 set requests a vertical flip. Both may be set together, and the other six bits are ignored.
- R4: The two bytes after the control byte form the row number, high byte first. At line end it appears in line_info[15:0] with line_info[31:16] zero.
- R5: Every three accepted payload bytes form one pixel word: the first byte in bits [7:0], the second in [15:8], the third in [23:16], and bits [31:24] zero. pix_wr is high for exactly the one clock after the third byte is accepted.
- R6: A packet carries exactly 512 pixels (1536 payload bytes), so every line produces exactly 512 pix_wr pulses. A 0x55 inside the payload is pixel data and does not restart framing.
- R7: line_end is a single-clock pulse that comes one clock after the 512th pix_wr of a line. The parser is then hunting for sync again.
- R8: flip_h, flip_v and line_info change only in the clock where line_end is high, so the flags of a line in progress never change.
- R9: A clock with rx_valid low consumes no byte, and rx_data is ignored in that clock. Any gap pattern between bytes gives the same outputs as a gapless stream, shifted in time.
- R10: A row number outside 0..383, such as 390, is forwarded unchanged as a normal line.
- R11: A truncated packet takes the following bytes as payload until its 1536 bytes are complete. The parser then discards bytes up to the next 0x55 and frames from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data carries a new byte this clock |
| pix_data | output | 32 | Packed pixel word |
| pix_wr | output | 1 | One-clock strobe for pix_data |
| line_end | output | 1 | One-clock pulse after the last pixel of a line |
| line_info | output | 32 | Row number of the line just completed |
| flip_h | output | 1 | Horizontal flip request of the last completed line |
| flip_v | output | 1 | Vertical flip request of the last completed line |

## Verification
Corruption of the byte-lane counter shows up at the very next pix_wr, because the bytes land in the wrong fields of pix_data. Corruption of the pixel counter or the framing state shows up only at the end of the line, where line_end comes early, late or not at all. It can also appear thousands of clocks later as one packet silently absorbing the next. For that reason the reference model is compared on every clock, and the pix_wr pulses between line ends are also counted. A wrongly staged control byte or row number stays hidden until the next line_end, where flip_h, flip_v or line_info differ.

// File: rtl/lpp_pkg.sv
package lpp_pkg;

   typedef enum logic [2:0] {
      ST_HUNT = 3'd0,
      ST_CTRL = 3'd1,
      ST_ROWH = 3'd2,
      ST_ROWL = 3'd3,
      ST_BODY = 3'd4
   } lpp_state_e;

   function automatic int lpp_cnt_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lpp_frame_fsm.sv
module lpp_frame_fsm
   import lpp_pkg::*;
#(
   parameter int                BYTE_W       = 8,
   parameter int                ROW_W        = 16,
   parameter int                PIX_PER_LINE = 512,
   parameter logic [BYTE_W-1:0] SYNC_CODE    = 8'h55
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_vld,
   input  logic              pix_done,
   output logic              body_vld,
   output logic              body_start,
   output logic              line_done,
   output logic [ROW_W-1:0]  row_idx,
   output logic [BYTE_W-1:0] ctrl_byte
);

   localparam int PCNT_W = lpp_cnt_w(PIX_PER_LINE);
   localparam logic [PCNT_W-1:0] PIX_LAST = PCNT_W'(PIX_PER_LINE - 1);

   lpp_state_e        state_q;
   logic [PCNT_W-1:0] pix_cnt_q;
   logic [BYTE_W-1:0] row_hi_q;
   logic [BYTE_W-1:0] ctrl_q;
   logic [ROW_W-1:0]  row_q;

   assign body_vld   = in_vld && (state_q == ST_BODY);
   assign body_start = in_vld && (state_q == ST_ROWL);
   assign line_done  = pix_done && (pix_cnt_q == PIX_LAST);
   assign row_idx    = row_q;
   assign ctrl_byte  = ctrl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_HUNT;
         pix_cnt_q <= '0;
         row_hi_q  <= '0;
         ctrl_q    <= '0;
         row_q     <= '0;
      end
      else if (in_vld) begin
         unique case (state_q)
            ST_HUNT: begin
               if (in_byte == SYNC_CODE)
                  state_q <= ST_CTRL;
            end
            ST_CTRL: begin
               ctrl_q  <= in_byte;
               state_q <= ST_ROWH;
            end
            ST_ROWH: begin
               row_hi_q <= in_byte;
               state_q  <= ST_ROWL;
            end
            ST_ROWL: begin
               row_q     <= {row_hi_q, in_byte};
               pix_cnt_q <= '0;
               state_q   <= ST_BODY;
            end
            ST_BODY: begin
               if (pix_done) begin
                  if (pix_cnt_q == PIX_LAST) begin
                     pix_cnt_q <= '0;
                     state_q   <= ST_HUNT;
                  end
                  else begin
                     pix_cnt_q <= pix_cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/lpp_pix_pack.sv
module lpp_pix_pack
   import lpp_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int BYTES_PER_PIX = 3,
   parameter int WORD_W        = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              in_vld,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              pix_done,
   output logic [WORD_W-1:0] pix_word,
   output logic              pix_we
);

   localparam int LANE_W = lpp_cnt_w(BYTES_PER_PIX);
   localparam int HOLD_N = (BYTES_PER_PIX > 1) ? BYTES_PER_PIX - 1 : 1;
   localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(BYTES_PER_PIX - 1);

   logic [LANE_W-1:0] lane_q;
   logic [BYTE_W-1:0] held_q [HOLD_N];
   logic [WORD_W-1:0] word_c;

   assign pix_done = in_vld && (lane_q == LANE_LAST);

   always_ff @(posedge clk) begin
      if (rst || clr)
         lane_q <= '0;
      else if (in_vld)
         lane_q <= pix_done ? '0 : lane_q + 1'b1;
   end

   for (genvar g = 0; g < BYTES_PER_PIX - 1; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)
            held_q[g] <= '0;
         else if (in_vld && (lane_q == LANE_W'(g)))
            held_q[g] <= in_byte;
      end
   end

   always_comb begin
      word_c = '0;
      for (int k = 0; k < BYTES_PER_PIX - 1; k++)
         word_c[k*BYTE_W +: BYTE_W] = held_q[k];
      word_c[(BYTES_PER_PIX-1)*BYTE_W +: BYTE_W] = in_byte;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pix_we   <= 1'b0;
         pix_word <= '0;
      end
      else begin
         pix_we <= pix_done;
         if (pix_done)
            pix_word <= word_c;
      end
   end

endmodule

// File: rtl/lpp_line_close.sv
module lpp_line_close #(
   parameter int BYTE_W    = 8,
   parameter int ROW_W     = 16,
   parameter int INFO_W    = 32,
   parameter int HFLIP_BIT = 4,
   parameter int VFLIP_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done_in,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [BYTE_W-1:0] ctrl_in,
   output logic              line_end,
   output logic [INFO_W-1:0] line_info,
   output logic              flip_h,
   output logic              flip_v
);

   logic              armed_q;
   logic [ROW_W-1:0]  row_stage_q;
   logic              h_stage_q;
   logic              v_stage_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q     <= 1'b0;
         row_stage_q <= '0;
         h_stage_q   <= 1'b0;
         v_stage_q   <= 1'b0;
      end
      else begin
         armed_q <= done_in;
         if (done_in) begin
            row_stage_q <= row_in;
            h_stage_q   <= ctrl_in[HFLIP_BIT];
            v_stage_q   <= ctrl_in[VFLIP_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         line_end  <= 1'b0;
         line_info <= '0;
         flip_h    <= 1'b0;
         flip_v    <= 1'b0;
      end
      else begin
         line_end <= armed_q;
         if (armed_q) begin
            line_info <= INFO_W'(row_stage_q);
            flip_h    <= h_stage_q;
            flip_v    <= v_stage_q;
         end
      end
   end

endmodule

// File: rtl/img_line_parser.sv
module img_line_parser #(
   parameter int                BYTE_W        = 8,
   parameter int                PIX_PER_LINE  = 512,
   parameter int                BYTES_PER_PIX = 3,
   parameter int                WORD_W        = 32,
   parameter int                ROW_W         = 16,
   parameter int                INFO_W        = 32,
   parameter logic [BYTE_W-1:0] SYNC_CODE     = 8'h55,
   parameter int                HFLIP_BIT     = 4,
   parameter int                VFLIP_BIT     = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic [WORD_W-1:0] pix_data,
   output logic              pix_wr,
   output logic              line_end,
   output logic [INFO_W-1:0] line_info,
   output logic              flip_h,
   output logic              flip_v
);

   if (ROW_W != 2 * BYTE_W) begin : g_bad_row
      $error("ROW_W must span exactly two bytes");
   end
   if (BYTES_PER_PIX * BYTE_W > WORD_W) begin : g_bad_word
      $error("pixel bytes do not fit the word");
   end
   if (INFO_W < ROW_W) begin : g_bad_info
      $error("INFO_W narrower than ROW_W");
   end
   if (HFLIP_BIT >= BYTE_W || VFLIP_BIT >= BYTE_W || HFLIP_BIT == VFLIP_BIT) begin : g_bad_flag
      $error("flip bit positions invalid");
   end
   if (PIX_PER_LINE < 2 || BYTES_PER_PIX < 1) begin : g_bad_line
      $error("line geometry too small");
   end

   logic              body_vld;
   logic              body_start;
   logic              pix_done;
   logic              line_done;
   logic [ROW_W-1:0]  row_idx;
   logic [BYTE_W-1:0] ctrl_byte;

   lpp_frame_fsm #(
      .BYTE_W       (BYTE_W),
      .ROW_W        (ROW_W),
      .PIX_PER_LINE (PIX_PER_LINE),
      .SYNC_CODE    (SYNC_CODE)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .in_byte    (rx_data),
      .in_vld     (rx_valid),
      .pix_done   (pix_done),
      .body_vld   (body_vld),
      .body_start (body_start),
      .line_done  (line_done),
      .row_idx    (row_idx),
      .ctrl_byte  (ctrl_byte)
   );

   lpp_pix_pack #(
      .BYTE_W        (BYTE_W),
      .BYTES_PER_PIX (BYTES_PER_PIX),
      .WORD_W        (WORD_W)
   ) u_pack (
      .clk      (clk),
      .rst      (rst),
      .clr      (body_start),
      .in_vld   (body_vld),
      .in_byte  (rx_data),
      .pix_done (pix_done),
      .pix_word (pix_data),
      .pix_we   (pix_wr)
   );

   lpp_line_close #(
      .BYTE_W    (BYTE_W),
      .ROW_W     (ROW_W),
      .INFO_W    (INFO_W),
      .HFLIP_BIT (HFLIP_BIT),
      .VFLIP_BIT (VFLIP_BIT)
   ) u_close (
      .clk       (clk),
      .rst       (rst),
      .done_in   (line_done),
      .row_in    (row_idx),
      .ctrl_in   (ctrl_byte),
      .line_end  (line_end),
      .line_info (line_info),
      .flip_h    (flip_h),
      .flip_v    (flip_v)
   );

endmodule

// File: rtl/img_line_parser_chk.sv
module img_line_parser_chk #(
   parameter int WORD_W = 32,
   parameter int PAY_W  = 24,
   parameter int INFO_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_valid,
   input logic [WORD_W-1:0] pix_data,
   input logic              pix_wr,
   input logic              line_end,
   input logic [INFO_W-1:0] line_info,
   input logic              flip_h,
   input logic              flip_v
);

   // R5
   pix_pad_chk: assert property (@(posedge clk) disable iff (rst)
      pix_wr |-> ((pix_data >> PAY_W) == '0));

   // R7
   end_after_pix_chk: assert property (@(posedge clk) disable iff (rst)
      line_end |-> $past(pix_wr));

   // R7
   end_single_chk: assert property (@(posedge clk) disable iff (rst)
      line_end |=> !line_end);

   // R8
   info_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(line_info) |-> line_end);

   // R8
   hflag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(flip_h) |-> line_end);

   // R8
   vflag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(flip_v) |-> line_end);

   // R9
   idle_no_pix_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rx_valid) |-> !pix_wr);

endmodule

bind img_line_parser img_line_parser_chk #(
   .WORD_W (WORD_W),
   .PAY_W  (BYTES_PER_PIX * BYTE_W),
   .INFO_W (INFO_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rx_valid  (rx_valid),
   .pix_data  (pix_data),
   .pix_wr    (pix_wr),
   .line_end  (line_end),
   .line_info (line_info),
   .flip_h    (flip_h),
   .flip_v    (flip_v)
);

// File: tb/sim_img_line_parser.sv
module sim_img_line_parser;

   localparam int PIX = 512;
   localparam int NBODY = PIX * 3;

   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic [31:0] pix_data;
   logic        pix_wr;
   logic        line_end;
   logic [31:0] line_info;
   logic        flip_h;
   logic        flip_v;

   always #5 clk = ~clk;

   img_line_parser u0 (
      .clk       (clk),
      .rst       (rst),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .pix_data  (pix_data),
      .pix_wr    (pix_wr),
      .line_end  (line_end),
      .line_info (line_info),
      .flip_h    (flip_h),
      .flip_v    (flip_v)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done_run = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   int          m_st;
   logic [7:0]  m_ctrl, m_hi;
   logic [15:0] m_row;
   logic [7:0]  m_q[$];
   int          m_npix;
   bit          m_done;
   logic [15:0] m_done_row;
   logic [7:0]  m_done_ctrl;
   int          m_lines;
   logic        e_we, e_le, e_h, e_v;
   logic [31:0] e_word, e_info;

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_npix = 0; m_done = 0; m_lines = 0; m_q.delete();
         e_we = 0; e_le = 0; e_h = 0; e_v = 0; e_word = 0; e_info = 0;
      end
      else begin
         e_we = 0;
         e_le = m_done;
         if (m_done) begin
            e_info = {16'h0, m_done_row};
            e_h = m_done_ctrl[4];
            e_v = m_done_ctrl[0];
            m_lines++;
         end
         m_done = 0;
         if (rx_valid) begin
            if (m_st == 0) begin
               if (rx_data == 8'h55) m_st = 1;
            end
            else if (m_st == 1) begin m_ctrl = rx_data; m_st = 2; end
            else if (m_st == 2) begin m_hi = rx_data; m_st = 3; end
            else if (m_st == 3) begin
               m_row = {m_hi, rx_data}; m_st = 4; m_npix = 0; m_q.delete();
            end
            else begin
               m_q.push_back(rx_data);
               if (m_q.size() == 3) begin
                  e_word = {8'h00, m_q[2], m_q[1], m_q[0]};
                  e_we = 1;
                  m_q.delete();
                  m_npix++;
                  if (m_npix == PIX) begin
                     m_done = 1; m_done_row = m_row; m_done_ctrl = m_ctrl; m_st = 0;
                  end
               end
            end
         end
      end
   end

   // per-clock comparison away from the active edge
   int dut_lines = 0;
   int pix_in_line = 0;
   logic [31:0] last_info;

   always @(negedge clk) begin
      if (!rst && !done_run) begin
         chk("R5", "pix_wr", {31'b0, pix_wr}, {31'b0, e_we});
         if (e_we) chk("R5", "pix_data", pix_data, e_word);
         chk("R7", "line_end", {31'b0, line_end}, {31'b0, e_le});
         chk("R4", "line_info", line_info, e_info);
         chk("R3", "flip_h", {31'b0, flip_h}, {31'b0, e_h});
         chk("R3", "flip_v", {31'b0, flip_v}, {31'b0, e_v});
         if (pix_wr) pix_in_line++;
         if (line_end) begin
            chk("R6", "pixels per line", pix_in_line, PIX);
            pix_in_line = 0;
            dut_lines++;
            last_info = line_info;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done_run) begin
         errors++;
         $display("FAIL watchdog all-requirements actual=%0d expected<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic put(input logic [7:0] b, input int gap);
      @(negedge clk);
      rx_data = b;
      rx_valid = 1'b1;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         rx_valid = 1'b0;
         rx_data = 8'h55;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b0;
         rx_data = 8'h00;
      end
   endtask

   task automatic packet(input logic [7:0] ctrl, input logic [15:0] row,
                         input int nbody, input int gap);
      put(8'h55, gap);
      put(ctrl, gap);
      put(row[15:8], gap);
      put(row[7:0], gap);
      for (int i = 0; i < nbody; i++)
         put(8'((i * 13 + int'(row)) & 8'hFF), (gap > 0 && (i % 5 == 0)) ? gap : 0);
   endtask

   initial begin
      rst = 1'b1;
      rx_valid = 1'b0;
      rx_data = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "pix_wr", {31'b0, pix_wr}, 32'h0);
      chk("R1", "line_end", {31'b0, line_end}, 32'h0);
      chk("R1", "pix_data", pix_data, 32'h0);
      chk("R1", "line_info", line_info, 32'h0);
      chk("R1", "flags", {30'b0, flip_h, flip_v}, 32'h0);
      rst = 1'b0;

      // R2: junk before sync discarded, then a horizontal-flip line (R3, R6: payload holds 0x55)
      put(8'h00, 0); put(8'hAA, 0); put(8'h54, 1); put(8'h56, 0);
      idle(2);
      chk("R2", "lines after junk", dut_lines, 0);
      packet(8'h10, 16'd5, NBODY, 0);
      idle(4);
      chk("R2", "lines after first packet", dut_lines, 1);
      chk("R3", "horizontal flag", {30'b0, flip_h, flip_v}, 32'h2);

      // R9: gaps with 0x55 on rx_data while idle; R4: row above 255 high byte first
      packet(8'h01, 16'h0102, NBODY, 2);
      idle(4);
      chk("R9", "lines with gaps", dut_lines, 2);
      chk("R4", "row high byte first", last_info, 32'h0000_0102);
      chk("R3", "vertical flag", {30'b0, flip_h, flip_v}, 32'h1);

      // R3: both flags
      packet(8'h11, 16'd383, NBODY, 0);
      idle(4);
      chk("R3", "both flags", {30'b0, flip_h, flip_v}, 32'h3);

      // R10: row beyond the image; R3: other control bits ignored
      packet(8'hEE, 16'd390, NBODY, 0);
      idle(4);
      chk("R10", "row 390 forwarded", last_info, 32'd390);
      chk("R3", "unused control bits", {30'b0, flip_h, flip_v}, 32'h0);
      chk("R7", "line count", dut_lines, 4);

      // R11: truncated packet absorbs following bytes, then resynchronises
      packet(8'h10, 16'd7, 100, 0);
      packet(8'h01, 16'd8, NBODY, 0);
      packet(8'h11, 16'd9, NBODY, 0);
      idle(2);
      for (int i = 0; i < 1600; i++) put(8'h00, 0);
      packet(8'h10, 16'd10, NBODY, 0);
      idle(6);
      chk("R11", "lines vs reference after truncation", dut_lines, m_lines);
      chk("R11", "final line row", last_info, 32'd10);

      done_run = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule